// File: doc/BRIEF.md
# Compact Load/Store Address and Lane Unit

This unit serves the memory stage of a core that runs short-form byte and halfword loads and stores. From the base register value, a tiny unsigned immediate and an access code, it forms the effective address. It also derives the 4-bit byte-enable mask and places the store data on the selected byte lanes. It raises a misalignment flag when a halfword access is not on a 2-byte boundary. When the 32-bit memory word comes back, it picks out the addressed byte or halfword and extends it.

The short instruction form encodes its base and data registers in 3-bit fields. Each field selects one of registers 8 to 15, and the unit expands both fields into full 5-bit register numbers for the register file. All paths are combinational. The unit has no timing or bus protocol of its own. Memory sequencing and the handling of the flag belong to the surrounding pipeline.

Top module: `cls_lane_unit`

## Requirements
- R1: The effective address equals the base value plus the zero-extended offset, with the sum wrapping modulo 2^32.
- R2: Byte accesses take the offset from both immediate bits, giving 0 to 3. Halfword accesses take only immediate bit 1, giving 0 or 2, and immediate bit 0 has no effect on them.
- R3: For byte accesses the mask is one-hot, with bit n set where n is address bits 1:0. A byte access never raises the misalignment flag.
- R4: An aligned halfword access drives mask 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1, with the flag low.
- R5: A halfword access whose address bit 0 is 1 raises the misalignment flag and drives mask 4'b0000.
- R6: A byte store copies source bits 7:0 onto all four byte lanes of the write data. A halfword store copies bits 15:0 onto both halves, whether or not it is aligned. Any other access code drives write data of zero.
- R7: The unsigned byte load returns the addressed byte zero-extended. The unsigned halfword load returns the addressed halfword zero-extended, and the signed halfword load returns it sign-extended from bit 15. Stores, misaligned halfword loads and unused codes return zero.
- R8: The access code is 3 bits: 0 unsigned byte load, 1 unsigned halfword load, 2 signed halfword load, 3 byte store, 4 halfword store. Codes 5 to 7 perform no access, which means mask 0, flag 0, address equal to the base, write data 0 and load result 0.
- R9: Each 3-bit register field f is expanded to the 5-bit register number 8 + f.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Access code (see R8) |
| base_i | input | 32 | Base register value |
| imm_i | input | 2 | Unsigned immediate |
| sdata_i | input | 32 | Store source register value |
| rdata_i | input | 32 | Word returned by memory for a load |
| base_sel_i | input | 3 | Compact base register field |
| data_sel_i | input | 3 | Compact data/destination register field |
| base_reg_o | output | 5 | Expanded base register number |
| data_reg_o | output | 5 | Expanded data/destination register number |
| addr_o | output | 32 | Effective address |
| be_o | output | 4 | Byte-enable mask |
| wdata_o | output | 32 | Lane-aligned store data |
| misalign_o | output | 1 | Halfword misalignment flag |
| load_o | output | 32 | Extended load result |

## Verification
The bench builds the unit with its default 32-bit address and data widths, so the mask has four lanes and the halfword lane pairs are 0 and 2. With that width, every byte lane can be reached through the immediate and the low base bits. The same setup exercises both halfword positions, address wrap-around past the top of the space, and sign extension with bit 15 both set and clear. It also covers an odd base, which makes a halfword misaligned while byte accesses at the same address stay legal.

// File: rtl/cls_pkg.sv
package cls_pkg;

  typedef enum logic [2:0] {
    ACC_LDBU = 3'd0,
    ACC_LDHU = 3'd1,
    ACC_LDHS = 3'd2,
    ACC_STB  = 3'd3,
    ACC_STH  = 3'd4
  } acc_e;

  localparam int unsigned ACC_W   = 3;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned REG_W   = 5;
  localparam int unsigned REG_BASE = 8;

  function automatic logic acc_is_byte(input logic [ACC_W-1:0] a);
    return (a == ACC_LDBU) || (a == ACC_STB);
  endfunction

  function automatic logic acc_is_half(input logic [ACC_W-1:0] a);
    return (a == ACC_LDHU) || (a == ACC_LDHS) || (a == ACC_STH);
  endfunction

  function automatic logic acc_is_store(input logic [ACC_W-1:0] a);
    return (a == ACC_STB) || (a == ACC_STH);
  endfunction

endpackage

// File: rtl/cls_reg_map.sv
module cls_reg_map
  import cls_pkg::*;
#(
  parameter int unsigned NUM_SEL = 2
) (
  input  logic [NUM_SEL*SEL_W-1:0] sel_i,
  output logic [NUM_SEL*REG_W-1:0] reg_o
);
  localparam logic [REG_W-1:0] OFFS = REG_W'(REG_BASE);

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_map
    assign reg_o[g*REG_W +: REG_W] = OFFS + REG_W'(sel_i[g*SEL_W +: SEL_W]);

    always_comb begin
      a_r9_upper_group: assert (reg_o[g*REG_W +: REG_W] >= OFFS)
        else $error("R9 register number below compact group");
    end
  end
endmodule

// File: rtl/cls_addr_gen.sv
module cls_addr_gen
  import cls_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ACC_W-1:0]  op_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [1:0]        imm_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              misalign_o
);
  logic [1:0] offs;

  always_comb begin
    if (acc_is_byte(op_i))      offs = imm_i;
    else if (acc_is_half(op_i)) offs = {imm_i[1], 1'b0};
    else                        offs = 2'b00;
  end

  assign addr_o     = base_i + ADDR_W'(offs);
  assign misalign_o = acc_is_half(op_i) & addr_o[0];

  always_comb begin
    a_r2_half_even_offset: assert (!acc_is_half(op_i) || (addr_o[0] == base_i[0]))
      else $error("R2 halfword offset changed address bit 0");
  end
endmodule

// File: rtl/cls_lane_ctl.sv
module cls_lane_ctl
  import cls_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / 8,
  localparam int unsigned LW    = $clog2(LANES)
) (
  input  logic [ACC_W-1:0]  op_i,
  input  logic [LW-1:0]     lane_i,
  input  logic              misalign_i,
  input  logic [DATA_W-1:0] sdata_i,
  output logic [LANES-1:0]  be_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam logic [LANES-1:0] ONE_LANE = LANES'(1);
  localparam logic [LANES-1:0] TWO_LANE = LANES'(3);

  logic [LW-1:0] pair_lane;
  assign pair_lane = {lane_i[LW-1:1], 1'b0};

  always_comb begin
    if (acc_is_byte(op_i))                    be_o = ONE_LANE << lane_i;
    else if (acc_is_half(op_i) && !misalign_i) be_o = TWO_LANE << pair_lane;
    else                                      be_o = '0;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      if (op_i == ACC_STB)      wdata_o[g*8 +: 8] = sdata_i[7:0];
      else if (op_i == ACC_STH) wdata_o[g*8 +: 8] = sdata_i[(g%2)*8 +: 8];
      else                      wdata_o[g*8 +: 8] = 8'h00;
    end
  end

  always_comb begin
    a_r4_half_pair: assert (!(acc_is_half(op_i) && !misalign_i) || ($countones(be_o) == 2))
      else $error("R4 aligned halfword mask not two lanes");
  end
endmodule

// File: rtl/cls_load_ext.sv
module cls_load_ext
  import cls_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / 8,
  localparam int unsigned LW    = $clog2(LANES)
) (
  input  logic [ACC_W-1:0]  op_i,
  input  logic [LW-1:0]     lane_i,
  input  logic              misalign_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] load_o
);
  logic [DATA_W-1:0] shifted;
  assign shifted = rdata_i >> {lane_i, 3'b000};

  always_comb begin
    if (misalign_i) load_o = '0;
    else begin
      unique case (op_i)
        ACC_LDBU: load_o = DATA_W'(shifted[7:0]);
        ACC_LDHU: load_o = DATA_W'(shifted[15:0]);
        ACC_LDHS: load_o = {{(DATA_W-16){shifted[15]}}, shifted[15:0]};
        default:  load_o = '0;
      endcase
    end
  end

  always_comb begin
    a_r7_sign_fill: assert ((op_i != ACC_LDHS) || misalign_i ||
                            (load_o[DATA_W-1:15] == '0) || (&load_o[DATA_W-1:15]))
      else $error("R7 signed halfword upper bits not uniform");
  end
endmodule

// File: rtl/cls_lane_unit.sv
module cls_lane_unit
  import cls_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / 8,
  localparam int unsigned LW    = $clog2(LANES)
) (
  input  logic [ACC_W-1:0]  op_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [1:0]        imm_i,
  input  logic [DATA_W-1:0] sdata_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [SEL_W-1:0]  base_sel_i,
  input  logic [SEL_W-1:0]  data_sel_i,
  output logic [REG_W-1:0]  base_reg_o,
  output logic [REG_W-1:0]  data_reg_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  be_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              misalign_o,
  output logic [DATA_W-1:0] load_o
);
  logic [LW-1:0] lane;

  cls_reg_map #(.NUM_SEL(2)) u_map (
    .sel_i ({data_sel_i, base_sel_i}),
    .reg_o ({data_reg_o, base_reg_o})
  );

  cls_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
    .op_i       (op_i),
    .base_i     (base_i),
    .imm_i      (imm_i),
    .addr_o     (addr_o),
    .misalign_o (misalign_o)
  );

  assign lane = addr_o[LW-1:0];

  cls_lane_ctl #(.DATA_W(DATA_W)) u_lanes (
    .op_i       (op_i),
    .lane_i     (lane),
    .misalign_i (misalign_o),
    .sdata_i    (sdata_i),
    .be_o       (be_o),
    .wdata_o    (wdata_o)
  );

  cls_load_ext #(.DATA_W(DATA_W)) u_ldx (
    .op_i       (op_i),
    .lane_i     (lane),
    .misalign_i (misalign_o),
    .rdata_i    (rdata_i),
    .load_o     (load_o)
  );

  always_comb begin
    a_r3_byte_onehot: assert (!acc_is_byte(op_i) || ($onehot(be_o) && !misalign_o))
      else $error("R3 byte access mask or flag wrong");
    a_r5_misalign_blocks: assert (!(acc_is_half(op_i) && addr_o[0]) || (be_o == '0 && misalign_o))
      else $error("R5 misaligned halfword still enabled");
    a_r8_idle_quiet: assert (acc_is_byte(op_i) || acc_is_half(op_i) ||
                             (be_o == '0 && !misalign_o && wdata_o == '0 && load_o == '0))
      else $error("R8 unused code produced activity");
  end
endmodule

// File: tb/cls_lane_unit_tb.sv
module cls_lane_unit_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] base;
    logic [1:0]  imm;
    logic [31:0] sd;
    logic [31:0] rd;
    logic [31:0] ea;
    logic [3:0]  be;
    logic [31:0] wd;
    logic        mis;
    logic [31:0] ld;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    // R1 R3 R7: byte load lane 3
    '{3'd0, 32'h0000_1000, 2'd3, 32'h0, 32'hA1B2_C3D4, 32'h0000_1003, 4'b1000, 32'h0, 1'b0, 32'h0000_00A1},
    // R3 R7: byte load from odd base, lane 1
    '{3'd0, 32'h0000_2001, 2'd0, 32'h0, 32'h1122_8344, 32'h0000_2001, 4'b0010, 32'h0, 1'b0, 32'h0000_0083},
    // R4 R7: unsigned halfword upper pair
    '{3'd1, 32'h0000_3000, 2'd2, 32'h0, 32'h8765_4321, 32'h0000_3002, 4'b1100, 32'h0, 1'b0, 32'h0000_8765},
    // R7: signed halfword upper pair, negative
    '{3'd2, 32'h0000_3000, 2'd2, 32'h0, 32'h8765_4321, 32'h0000_3002, 4'b1100, 32'h0, 1'b0, 32'hFFFF_8765},
    // R2: halfword ignores imm bit 0
    '{3'd2, 32'h0000_3000, 2'd1, 32'h0, 32'h1234_F00D, 32'h0000_3000, 4'b0011, 32'h0, 1'b0, 32'hFFFF_F00D},
    // R5: misaligned signed halfword
    '{3'd2, 32'h0000_3001, 2'd0, 32'h0, 32'hFFFF_FFFF, 32'h0000_3001, 4'b0000, 32'h0, 1'b1, 32'h0},
    // R5: misaligned unsigned halfword with offset
    '{3'd1, 32'h0000_3003, 2'd2, 32'h0, 32'hFFFF_FFFF, 32'h0000_3005, 4'b0000, 32'h0, 1'b1, 32'h0},
    // R7: signed halfword positive
    '{3'd2, 32'h0000_4000, 2'd0, 32'h0, 32'hFFFF_7FFF, 32'h0000_4000, 4'b0011, 32'h0, 1'b0, 32'h0000_7FFF},
    // R6: byte store replicated
    '{3'd3, 32'h0000_5000, 2'd2, 32'hDEAD_BE5A, 32'hFFFF_FFFF, 32'h0000_5002, 4'b0100, 32'h5A5A_5A5A, 1'b0, 32'h0},
    // R6 R4: halfword store lower pair
    '{3'd4, 32'h0000_5002, 2'd2, 32'hCAFE_1234, 32'h0, 32'h0000_5004, 4'b0011, 32'h1234_1234, 1'b0, 32'h0},
    // R5 R6: misaligned halfword store
    '{3'd4, 32'h0000_5001, 2'd0, 32'hCAFE_1234, 32'h0, 32'h0000_5001, 4'b0000, 32'h1234_1234, 1'b1, 32'h0},
    // R3 R6: byte store at odd address never flags
    '{3'd3, 32'h0000_5003, 2'd3, 32'h0000_00FF, 32'h0, 32'h0000_5006, 4'b0100, 32'hFFFF_FFFF, 1'b0, 32'h0},
    // R8: unused code 7
    '{3'd7, 32'h0000_0010, 2'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0010, 4'b0000, 32'h0, 1'b0, 32'h0},
    // R1: wrap past top of address space
    '{3'd0, 32'hFFFF_FFFF, 2'd1, 32'h0, 32'h0000_00C8, 32'h0000_0000, 4'b0001, 32'h0, 1'b0, 32'h0000_00C8}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [2:0]  op;
  logic [31:0] base, sdata, rdata;
  logic [1:0]  imm;
  logic [2:0]  bsel, dsel;
  logic [4:0]  breg, dreg;
  logic [31:0] addr, wdata, ldv;
  logic [3:0]  be;
  logic        mis;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  cls_lane_unit u_dut (
    .op_i(op), .base_i(base), .imm_i(imm), .sdata_i(sdata), .rdata_i(rdata),
    .base_sel_i(bsel), .data_sel_i(dsel), .base_reg_o(breg), .data_reg_o(dreg),
    .addr_o(addr), .be_o(be), .wdata_o(wdata), .misalign_o(mis), .load_o(ldv)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<5000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    op = 3'd7; base = '0; imm = '0; sdata = '0; rdata = '0; bsel = '0; dsel = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // idle state after reset: R8 no access
    chk("R8 idle be", {28'h0, be}, 32'h0);
    chk("R8 idle misalign", {31'h0, mis}, 32'h0);
    chk("R8 idle load", ldv, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      op = VECS[i].op; base = VECS[i].base; imm = VECS[i].imm;
      sdata = VECS[i].sd; rdata = VECS[i].rd;
      @(negedge clk);
      chk($sformatf("R1 addr v%0d", i), addr, VECS[i].ea);
      chk($sformatf("R3/R4/R5 be v%0d", i), {28'h0, be}, {28'h0, VECS[i].be});
      chk($sformatf("R6 wdata v%0d", i), wdata, VECS[i].wd);
      chk($sformatf("R5 misalign v%0d", i), {31'h0, mis}, {31'h0, VECS[i].mis});
      chk($sformatf("R7 load v%0d", i), ldv, VECS[i].ld);
    end

    // R9 register field expansion corners
    for (int f = 0; f < 8; f++) begin
      @(posedge clk);
      bsel = 3'(f); dsel = 3'(7 - f);
      @(negedge clk);
      chk("R9 base reg", {27'h0, breg}, 32'(8 + f));
      chk("R9 data reg", {27'h0, dreg}, 32'(15 - f));
    end

    // R3 every byte lane reachable, R2 imm bit 0 on halfword irrelevant
    for (int l = 0; l < 4; l++) begin
      @(posedge clk);
      op = 3'd3; base = 32'h0000_8000; imm = 2'(l); sdata = 32'h0000_0077;
      @(negedge clk);
      chk("R3 byte lane mask", {28'h0, be}, 32'(1 << l));
      chk("R3 byte no flag", {31'h0, mis}, 32'h0);
    end
    @(posedge clk);
    op = 3'd1; base = 32'h0000_8000; imm = 2'd3; rdata = 32'hBEEF_0001;
    @(negedge clk);
    chk("R2 half imm=3 addr", addr, 32'h0000_8002);
    chk("R2 half imm=3 load", ldv, 32'h0000_BEEF);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule